// File: doc/BRIEF.md
# Warp Lane Mask Sequencer

This block keeps track of which of the 32 lanes in a thread group may commit results while the whole group shares a single instruction pointer. When the group reaches a data-dependent branch, the issuing logic hands the unit a per-lane condition vector. The unit first narrows the active mask to the lanes whose condition is true. Later, on the else command, it switches to the lanes that were active before the branch but whose condition was false. Every lane still executes every issued instruction. Only the per-lane write-enable decides whether a result is kept or dropped.

A four-entry reconvergence stack holds the mask that was active before each open branch, together with the lanes still waiting for the other side. Branches can therefore be nested. At end-if the outer mask is restored. If one side of a branch has no live lanes, the unit raises a skip pulse so that the sequencer can jump over that side and spend no cycles on it. Commands that make no sense in the current state raise a one-cycle error pulse and leave the mask untouched. These are an end-if or else with no open branch, a second else, and a branch with the stack full.

Commands take effect at the clock edge where they are sampled. The new mask, skip and error values appear on the outputs in the following cycle.

Top module: `warp_mask_unit`

## Requirements
- R1: After reset the active mask is all ones (all 32 lanes live), no branch is open, and both the skip and the error outputs are low.
- R2: A branch command with condition vector C, while the mask is M, pushes M and sets the mask to M AND C in the next cycle, provided M AND C is nonzero.
- R3: An else command on an open branch sets the mask to M AND NOT C, using the M and C of that branch. These are exactly the lanes that were live before the branch and were excluded from the taken side.
- R4: An end-if command pops the innermost open branch and restores the mask that was active before it.
- R5: The per-lane write-enable equals the lane's mask bit ANDed with the global issue-valid input, in the same cycle.
- R6: If M AND C is zero at a branch, the unit pulses skip for one cycle and goes straight to mask M AND NOT C. A later else on that branch is then an error.
- R7: If M AND NOT C is zero, the else command pulses skip for one cycle and sets the mask to all zeros until end-if.
- R8: Branches nest up to four levels deep, and each end-if restores the mask of its own level.
- R9: A branch command while four branches are open pulses the error output and leaves the mask and the stack unchanged.
- R10: An end-if or else with no open branch, or a second else on the same branch, pulses the error output and leaves the mask unchanged.
- R11: When several commands arrive in one cycle, branch wins over else and else wins over end-if. The losing commands are dropped.
- R12: For any branch, the live-lane count of the taken side plus that of the not-taken side equals the live-lane count before the branch. For example, 1 and 31 under a full mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_req | input | 1 | Open a branch using br_cond |
| br_cond | input | 32 | Per-lane branch condition, bit i for lane i |
| else_req | input | 1 | Switch to the not-taken side of the innermost branch |
| endif_req | input | 1 | Close the innermost branch and restore its outer mask |
| issue_valid | input | 1 | Global valid of the instruction issued this cycle |
| act_mask | output | 32 | Current active lane mask |
| lane_we | output | 32 | Per-lane write-enable to the lane datapath |
| path_skip | output | 1 | One-cycle pulse: the side just entered has no live lanes |
| seq_err | output | 1 | One-cycle pulse: the last command was illegal and was ignored |

## Verification
The bench compares the outputs against a queue-based model on every cycle. It drives hand-built patterns first, then a long random command stream. A single-lane condition followed by its complement shows that the two sides partition the outer mask and are not simply inverted from all ones. All-false and all-true conditions separate the skip taken at branch time from the skip taken at else time. Four-deep nesting with overlapping conditions shows that each end-if restores its own level and not the reset mask. Simultaneous commands and commands on an empty or full stack expose the priority order and the error path.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_BRANCH = 2'd1,
    CMD_ELSE   = 2'd2,
    CMD_ENDIF  = 2'd3
  } wm_cmd_e;
endpackage

// File: rtl/wm_stack.sv
module wm_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             mark_i,
  input  logic [LANES-1:0] push_saved_i,
  input  logic [LANES-1:0] push_other_i,
  input  logic             push_else_i,
  output logic [LANES-1:0] top_saved_o,
  output logic [LANES-1:0] top_other_o,
  output logic             top_else_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]    sp_q, sp_d;
  logic [IW-1:0]    top_idx;
  logic [LANES-1:0] saved_w [DEPTH];
  logic [LANES-1:0] other_w [DEPTH];
  logic             else_w  [DEPTH];

  always_comb begin
    sp_d = sp_q;
    if (push_i)     sp_d = sp_q + PW'(1);
    else if (pop_i) sp_d = sp_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      logic [LANES-1:0] sv_q, ot_q;
      logic             el_q;
      logic             wr_en, mk_en;
      assign wr_en = push_i && (sp_q == PW'(g));
      assign mk_en = mark_i && (sp_q == PW'(g + 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv_q <= '0;
          ot_q <= '0;
          el_q <= 1'b0;
        end else if (wr_en) begin
          sv_q <= push_saved_i;
          ot_q <= push_other_i;
          el_q <= push_else_i;
        end else if (mk_en) begin
          el_q <= 1'b1;
        end
      end
      assign saved_w[g] = sv_q;
      assign other_w[g] = ot_q;
      assign else_w[g]  = el_q;
    end
  endgenerate

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == PW'(DEPTH));
  assign top_idx = empty_o ? '0 : IW'(sp_q - PW'(1));

  assign top_saved_o = empty_o ? '0   : saved_w[top_idx];
  assign top_other_o = empty_o ? '0   : other_w[top_idx];
  assign top_else_o  = empty_o ? 1'b0 : else_w[top_idx];
endmodule

// File: rtl/wm_ctrl.sv
module wm_ctrl
  import wm_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_req,
  input  logic [LANES-1:0] br_cond,
  input  logic             else_req,
  input  logic             endif_req,
  input  logic [LANES-1:0] top_saved_i,
  input  logic [LANES-1:0] top_other_i,
  input  logic             top_else_i,
  input  logic             empty_i,
  input  logic             full_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             mark_o,
  output logic [LANES-1:0] push_saved_o,
  output logic [LANES-1:0] push_other_o,
  output logic             push_else_o,
  output logic [LANES-1:0] mask_o,
  output logic             skip_o,
  output logic             err_o
);
  wm_cmd_e          cmd;
  logic [LANES-1:0] mask_q, mask_d;
  logic             skip_q, skip_d;
  logic             err_q, err_d;
  logic [LANES-1:0] taken, not_taken;

  always_comb begin
    if (br_req)         cmd = CMD_BRANCH;
    else if (else_req)  cmd = CMD_ELSE;
    else if (endif_req) cmd = CMD_ENDIF;
    else                cmd = CMD_IDLE;
  end

  assign taken     = mask_q & br_cond;
  assign not_taken = mask_q & ~br_cond;

  always_comb begin
    mask_d       = mask_q;
    skip_d       = 1'b0;
    err_d        = 1'b0;
    push_o       = 1'b0;
    pop_o        = 1'b0;
    mark_o       = 1'b0;
    push_saved_o = mask_q;
    push_other_o = not_taken;
    push_else_o  = 1'b0;
    unique case (cmd)
      CMD_BRANCH: begin
        if (full_i) begin
          err_d = 1'b1;
        end else begin
          push_o = 1'b1;
          if (taken == '0) begin
            push_else_o = 1'b1;
            skip_d      = 1'b1;
            mask_d      = not_taken;
          end else begin
            mask_d = taken;
          end
        end
      end
      CMD_ELSE: begin
        if (empty_i || top_else_i) begin
          err_d = 1'b1;
        end else begin
          mark_o = 1'b1;
          mask_d = top_other_i;
          skip_d = (top_other_i == '0);
        end
      end
      CMD_ENDIF: begin
        if (empty_i) begin
          err_d = 1'b1;
        end else begin
          pop_o  = 1'b1;
          mask_d = top_saved_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      skip_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      skip_q <= skip_d;
      err_q  <= err_d;
    end
  end

  assign mask_o = mask_q;
  assign skip_o = skip_q;
  assign err_o  = err_q;
endmodule

// File: rtl/wm_gate.sv
module wm_gate #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] mask_i,
  input  logic             valid_i,
  output logic [LANES-1:0] we_o
);
  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign we_o[l] = mask_i[l] & valid_i;
    end
  endgenerate
endmodule

// File: rtl/warp_mask_unit.sv
module warp_mask_unit #(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_req,
  input  logic [LANES-1:0] br_cond,
  input  logic             else_req,
  input  logic             endif_req,
  input  logic             issue_valid,
  output logic [LANES-1:0] act_mask,
  output logic [LANES-1:0] lane_we,
  output logic             path_skip,
  output logic             seq_err
);
  logic             push, pop, mark, push_else, top_else, empty, full;
  logic [LANES-1:0] push_saved, push_other, top_saved, top_other;

  wm_stack #(.LANES(LANES), .DEPTH(DEPTH)) stack_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push),
    .pop_i        (pop),
    .mark_i       (mark),
    .push_saved_i (push_saved),
    .push_other_i (push_other),
    .push_else_i  (push_else),
    .top_saved_o  (top_saved),
    .top_other_o  (top_other),
    .top_else_o   (top_else),
    .empty_o      (empty),
    .full_o       (full)
  );

  wm_ctrl #(.LANES(LANES)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_req       (br_req),
    .br_cond      (br_cond),
    .else_req     (else_req),
    .endif_req    (endif_req),
    .top_saved_i  (top_saved),
    .top_other_i  (top_other),
    .top_else_i   (top_else),
    .empty_i      (empty),
    .full_i       (full),
    .push_o       (push),
    .pop_o        (pop),
    .mark_o       (mark),
    .push_saved_o (push_saved),
    .push_other_o (push_other),
    .push_else_o  (push_else),
    .mask_o       (act_mask),
    .skip_o       (path_skip),
    .err_o        (seq_err)
  );

  wm_gate #(.LANES(LANES)) gate_i (
    .mask_i  (act_mask),
    .valid_i (issue_valid),
    .we_o    (lane_we)
  );
endmodule

// File: rtl/wm_chk.sv
module wm_chk #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_req,
  input logic [LANES-1:0] br_cond,
  input logic             else_req,
  input logic             endif_req,
  input logic             issue_valid,
  input logic [LANES-1:0] act_mask,
  input logic [LANES-1:0] lane_we,
  input logic             path_skip,
  input logic             seq_err
);
  logic else_only;
  assign else_only = else_req && !br_req;

  // R5: write-enable follows mask gated by issue valid
  assert_we_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we == (act_mask & {LANES{issue_valid}}));

  // R2: a branch only ever removes lanes from the mask
  assert_branch_narrows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |=> (seq_err || ((act_mask & ~$past(act_mask)) == '0)));

  // R3: the else side shares no lane with the side it replaces
  assert_else_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    else_only |=> (seq_err || ((act_mask & $past(act_mask)) == '0)));

  // R10: an illegal command leaves the mask untouched
  assert_err_holds_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (act_mask == $past(act_mask)));

  // R6: a skip is never reported for a rejected command
  assert_skip_not_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(path_skip && seq_err));

  // R11: with no command the mask holds
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_req && !else_req && !endif_req) |=> $stable(act_mask));
endmodule

bind warp_mask_unit wm_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/warp_mask_unit_tb_top.sv
module warp_mask_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        br_req, else_req, endif_req, issue_valid;
  logic [31:0] br_cond;
  logic [31:0] act_mask, lane_we;
  logic        path_skip, seq_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  logic [31:0] m_mask;
  bit          m_skip, m_err;
  logic [31:0] qs[$];
  logic [31:0] qo[$];
  bit          qe[$];

  warp_mask_unit dut_i (
    .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_cond(br_cond),
    .else_req(else_req), .endif_req(endif_req), .issue_valid(issue_valid),
    .act_mask(act_mask), .lane_we(lane_we), .path_skip(path_skip),
    .seq_err(seq_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '1; m_skip = 0; m_err = 0;
      qs.delete(); qo.delete(); qe.delete();
    end else begin
      logic [31:0] t, n;
      m_skip = 0; m_err = 0;
      t = m_mask & br_cond;
      n = m_mask & ~br_cond;
      if (br_req) begin
        if (qs.size() == 4) m_err = 1;
        else begin
          qs.push_back(m_mask); qo.push_back(n);
          if (t == 0) begin qe.push_back(1); m_mask = n; m_skip = 1; end
          else begin qe.push_back(0); m_mask = t; end
        end
      end else if (else_req) begin
        if (qs.size() == 0 || qe[qe.size()-1]) m_err = 1;
        else begin
          qe[qe.size()-1] = 1;
          m_mask = qo[qo.size()-1];
          m_skip = (m_mask == 0);
        end
      end else if (endif_req) begin
        if (qs.size() == 0) m_err = 1;
        else begin
          m_mask = qs.pop_back();
          void'(qo.pop_back());
          void'(qe.pop_back());
        end
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      checks++;
      if (act_mask !== m_mask || lane_we !== (m_mask & {32{issue_valid}}) ||
          path_skip !== m_skip || seq_err !== m_err) begin
        errors++;
        $display("FAIL %s cycle %0d: mask %h we %h skip %0b err %0b, expected mask %h we %h skip %0b err %0b",
                 tag, cycles, act_mask, lane_we, path_skip, seq_err,
                 m_mask, m_mask & {32{issue_valid}}, m_skip, m_err);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic op(input bit b, input bit e, input bit x, input logic [31:0] c);
    @(negedge clk);
    br_req = b; else_req = e; endif_req = x; br_cond = c;
    @(negedge clk);
    br_req = 0; else_req = 0; endif_req = 0; br_cond = '0;
  endtask

  initial begin
    rst_n = 0; br_req = 0; else_req = 0; endif_req = 0; br_cond = '0; issue_valid = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk("R1 mask", act_mask, 32'hFFFF_FFFF);
    chk("R1 flags", {30'd0, path_skip, seq_err}, 32'd0);

    tag = "R5";
    issue_valid = 0; @(negedge clk);
    chk("R5 we low", lane_we, 32'd0);
    issue_valid = 1; @(negedge clk);
    chk("R5 we high", lane_we, 32'hFFFF_FFFF);

    tag = "R2";
    op(1, 0, 0, 32'h0000_0001);
    chk("R2 taken", act_mask, 32'h0000_0001);
    chk("R12 taken count", $countones(act_mask), 1);
    tag = "R3";
    op(0, 1, 0, '0);
    chk("R3 other", act_mask, 32'hFFFF_FFFE);
    chk("R12 other count", $countones(act_mask), 31);
    tag = "R4";
    op(0, 0, 1, '0);
    chk("R4 restore", act_mask, 32'hFFFF_FFFF);

    tag = "R6";
    op(1, 0, 0, 32'h0);
    chk("R6 skip", {31'd0, path_skip}, 1);
    chk("R6 mask", act_mask, 32'hFFFF_FFFF);
    op(0, 1, 0, '0);
    chk("R6 second else err", {31'd0, seq_err}, 1);
    op(0, 0, 1, '0);

    tag = "R7";
    op(1, 0, 0, 32'hFFFF_FFFF);
    chk("R7 no skip at branch", {31'd0, path_skip}, 0);
    op(0, 1, 0, '0);
    chk("R7 skip", {31'd0, path_skip}, 1);
    chk("R7 mask zero", act_mask, 32'd0);
    op(0, 0, 1, '0);

    tag = "R8";
    op(1, 0, 0, 32'h00FF_FF00);
    op(1, 0, 0, 32'h0F0F_0F0F);
    chk("R8 level2", act_mask, 32'h000F_0F00);
    op(1, 0, 0, 32'h0003_0300);
    op(1, 0, 0, 32'h0001_0000);
    chk("R8 level4", act_mask, 32'h0001_0000);
    tag = "R9";
    op(1, 0, 0, 32'hFFFF_FFFF);
    chk("R9 full err", {31'd0, seq_err}, 1);
    chk("R9 mask kept", act_mask, 32'h0001_0000);
    tag = "R8";
    op(0, 1, 0, '0);
    chk("R8 level4 else", act_mask, 32'h0002_0300);
    op(0, 0, 1, '0);
    op(0, 0, 1, '0);
    chk("R8 level2 restore", act_mask, 32'h000F_0F00);
    op(0, 1, 0, '0);
    chk("R8 level2 else", act_mask, 32'h00F0_F000);
    op(0, 0, 1, '0);
    op(0, 0, 1, '0);
    chk("R8 top restore", act_mask, 32'hFFFF_FFFF);

    tag = "R10";
    op(0, 0, 1, '0);
    chk("R10 endif empty", {31'd0, seq_err}, 1);
    op(0, 1, 0, '0);
    chk("R10 else empty", {31'd0, seq_err}, 1);
    chk("R10 mask kept", act_mask, 32'hFFFF_FFFF);

    tag = "R11";
    op(1, 1, 1, 32'h0000_FFFF);
    chk("R11 branch wins", act_mask, 32'h0000_FFFF);
    op(0, 1, 1, '0);
    chk("R11 else wins", act_mask, 32'hFFFF_0000);
    op(0, 0, 1, '0);
    chk("R11 closed", act_mask, 32'hFFFF_FFFF);

    tag = "random R2 R3 R4 R6 R7";
    for (int i = 0; i < 3000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      br_req = (r < 25); else_req = (r >= 20 && r < 45); endif_req = (r >= 40 && r < 70);
      case ($urandom_range(0, 5))
        0: br_cond = '0;
        1: br_cond = '1;
        default: br_cond = $urandom();
      endcase
      issue_valid = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    br_req = 0; else_req = 0; endif_req = 0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule